// File: doc/BRIEF.md
# Context Exchange Sequencer

This block carries out a hardware context switch. The processor's sixteen 60-bit registers and a sixteen-word exchange package in memory trade places: every register value goes out to the package while the package word at the same position comes in to the register. The swap is started either by the processor's own exchange instruction or by a forced exchange from an external supervisory controller.

The package address depends on what started the exchange and on the privilege of the running context. An error trigger selects the error exchange address. An unprivileged context can only reach the normal exchange address from its own state. A privileged context, and any forced exchange, goes to the address given with the request. The exchange always takes a fixed number of cycles, so the first instruction of the new context issues at a known time.

The memory port is single-ported and read-first. In one cycle it returns the old contents of an address and stores new data there. This lets the block move one word per cycle. The block then pads the exchange to its fixed length.

Top module: `xchg_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, `busy`, `done`, `mem_en`, `mem_we` and `rf_we` are all 0.
- R2: An instruction exchange (`xj_req`=1, `xj_err`=0, `force_req`=0) from an unprivileged context (`priv`=0) uses `norm_addr` as the package base.
- R3: An instruction exchange with `xj_err`=1 uses `err_addr` as the package base, whatever the value of `priv`.
- R4: An instruction exchange with `xj_err`=0 from a privileged context (`priv`=1) uses `req_addr` as the package base.
- R5: A forced exchange (`force_req`=1) uses `force_addr` and takes priority over an `xj_req` in the same cycle.
- R6: After a request is accepted, `busy` is high for exactly LAT (28) consecutive cycles, beginning with the cycle after the accepting edge. `done` is high in the last of those cycles and in no other cycle.
- R7: The memory is read-first: when `mem_en` is high, `mem_rdata` on the next cycle holds the old word at `mem_addr`, and `mem_wdata` is stored there. When an exchange ends, register k holds the package word that was at base+k, and base+k holds the old value of register k, for k = 0..15.
- R8: In the first 16 busy cycles, `mem_en` and `mem_we` are high and `mem_addr` steps from base up to base+15, one address per cycle.
- R9: A request that arrives while `busy` is high is ignored. The running exchange keeps its length and its target, and memory outside that target is left unchanged.
- R10: When `busy` is low, the block drives no memory access and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xj_req | input | 1 | Exchange instruction ready to issue |
| xj_err | input | 1 | The exchange is caused by an error condition |
| priv | input | 1 | The current context is privileged |
| force_req | input | 1 | Forced exchange from the supervisory controller |
| req_addr | input | AW | Target address given with a privileged request |
| norm_addr | input | AW | Normal exchange address of the current context |
| err_addr | input | AW | Error exchange address of the current context |
| force_addr | input | AW | Target address of a forced exchange |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Last cycle of the exchange; the new context issues next |
| mem_en | output | 1 | Memory access enable (read-first) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Outgoing register value |
| mem_rdata | input | DW | Old memory word, one cycle after the access |
| rf_ridx | output | IW | Register read index |
| rf_rdata | input | DW | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_widx | output | IW | Register write index |
| rf_wdata | output | DW | Incoming package word |

## Verification
Four request patterns exercise target selection: unprivileged normal, error with privilege set, privileged normal, and a forced exchange raised together with an instruction request. Each pattern has its own address, so a wrong priority or a wrong mux leg shows up as data swapped at the wrong package. Register and package contents use different tagged patterns, so a missed swap, a write to the wrong index or an off-by-one in the write-back each give a distinct mismatch. One further run raises both request kinds in the middle of an exchange. It confirms that the length, the target and an unrelated package region do not change.

// File: rtl/xchg_seq.sv
module xchg_seq #(
  parameter int WORDS = 16,
  parameter int DW    = 60,
  parameter int AW    = 18,
  parameter int LAT   = 28,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xj_req,
  input  logic          xj_err,
  input  logic          priv,
  input  logic          force_req,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] norm_addr,
  input  logic [AW-1:0] err_addr,
  input  logic [AW-1:0] force_addr,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [IW-1:0] rf_ridx,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [IW-1:0] rf_widx,
  output logic [DW-1:0] rf_wdata
);

  logic          run;
  logic [CW-1:0] cnt;
  logic [AW-1:0] base;
  logic [AW-1:0] tgt;
  logic          start;

  assign start = !run && (force_req || xj_req);

  always_comb begin
    if (force_req)   tgt = force_addr;
    else if (xj_err) tgt = err_addr;
    else if (priv)   tgt = req_addr;
    else             tgt = norm_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      base <= '0;
    end else if (start) begin
      run  <= 1'b1;
      cnt  <= '0;
      base <= tgt;
    end else if (run) begin
      if (cnt == CW'(LAT - 1)) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign busy      = run;
  assign done      = run && (cnt == CW'(LAT - 1));
  assign mem_en    = run && (cnt < CW'(WORDS));
  assign mem_we    = mem_en;
  assign mem_addr  = base + AW'(cnt);
  assign rf_ridx   = IW'(cnt);
  assign mem_wdata = rf_rdata;
  assign rf_we     = run && (cnt != '0) && (cnt <= CW'(WORDS));
  assign rf_widx   = IW'(cnt - CW'(1));
  assign rf_wdata  = mem_rdata;

endmodule

module xchg_seq_chk #(
  parameter int WORDS = 16,
  parameter int AW    = 18,
  parameter int LAT   = 28,
  localparam int IW   = $clog2(WORDS),
  localparam int CW   = $clog2(LAT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xj_req,
  input logic          xj_err,
  input logic          priv,
  input logic          force_req,
  input logic [AW-1:0] req_addr,
  input logic [AW-1:0] norm_addr,
  input logic [AW-1:0] err_addr,
  input logic [AW-1:0] force_addr,
  input logic          busy,
  input logic          done,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] rf_ridx,
  input logic          rf_we,
  input logic [IW-1:0] rf_widx
);

  logic [CW-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + CW'(1);
    else           bcnt <= '0;
  end

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!busy && !done && !mem_en && !rf_we); // R1

  AST_NORM_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xj_req && !force_req && !xj_err && !priv) |=> mem_addr == $past(norm_addr)); // R2
  AST_ERR_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xj_req && !force_req && xj_err) |=> mem_addr == $past(err_addr)); // R3
  AST_PRIV_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xj_req && !force_req && !xj_err && priv) |=> mem_addr == $past(req_addr)); // R4
  AST_FORCE_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && force_req) |=> mem_addr == $past(force_addr)); // R5
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && bcnt == CW'(LAT - 1))); // R6
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < CW'(LAT)); // R6
  AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done)); // R6
  AST_WB_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ($past(mem_en) && rf_widx == $past(rf_ridx))); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> mem_addr == $past(mem_addr) + AW'(1)); // R8
  AST_IGNORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && (xj_req || force_req)) |=> busy); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !rf_we)); // R10

endmodule

bind xchg_seq xchg_seq_chk #(.WORDS(WORDS), .AW(AW), .LAT(LAT)) u_chk (.*);

// File: tb/tb_xchg_seq.sv
module tb_xchg_seq;
  localparam int WORDS = 16;
  localparam int DW    = 60;
  localparam int AW    = 18;
  localparam int LAT   = 28;
  localparam int IW    = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xj_req = 1'b0, xj_err = 1'b0, priv = 1'b0, force_req = 1'b0;
  logic [AW-1:0] req_addr = '0, norm_addr = '0, err_addr = '0, force_addr = '0;
  logic busy, done, mem_en, mem_we, rf_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rf_rdata, rf_wdata;
  logic [IW-1:0] rf_ridx, rf_widx;

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] regs [0:WORDS-1];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  xchg_seq dut (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end
  assign rf_rdata = regs[rf_ridx];
  always @(posedge clk) if (rf_we) regs[rf_widx] <= rf_wdata;

  function automatic logic [DW-1:0] pat(input int seed, input int k);
    return {seed[15:0], 12'h5a3, 32'(k)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int base, input int mseed, input int rseed);
    for (int k = 0; k < 256; k++) mem[k] = pat(99, k);
    for (int k = 0; k < WORDS; k++) begin
      mem[base + k] = pat(mseed, k);
      regs[k] = pat(rseed, k);
    end
  endtask

  // fires one exchange; optional mid-run request at busy cycle 5
  task automatic run_xchg(input string req, input int base, input bit intrude);
    int cyc = 0, dn = 0, dpos = 0, bad = 0;
    logic [AW-1:0] first;
    @(posedge clk);
    @(negedge clk);
    xj_req = 1'b0; force_req = 1'b0;
    first = mem_addr;
    check(mem_addr == AW'(base), req, mem_addr, base);
    while (busy) begin
      cyc++;
      if (done) begin dn++; dpos = cyc; end
      if (intrude && cyc == 5) begin
        xj_req = 1'b1; force_req = 1'b1; priv = 1'b1;
        req_addr = 18'd200; force_addr = 18'd200;
      end
      if (intrude && cyc == 8) begin xj_req = 1'b0; force_req = 1'b0; end
      @(negedge clk);
    end
    check(cyc == LAT, "R6 busy length", cyc, LAT);
    check(dn == 1 && dpos == LAT, "R6 done position", dpos, LAT);
    for (int k = 0; k < WORDS; k++) begin
      if (regs[k] !== pat(1, k)) bad++;
      if (mem[base + k] !== pat(2, k)) bad++;
    end
    check(bad == 0, "R7 swap contents", bad, 0);
    check(first == AW'(base), "R8 first address", first, base);
  endtask

  task automatic t_reset;
    check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    check(!mem_en && !mem_we && !rf_we, "R1 strobes in reset", {mem_en, mem_we, rf_we}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    check(!mem_en && !rf_we, "R10 quiet when idle", {mem_en, rf_we}, 0);
  endtask

  task automatic t_unpriv;
    fill(16, 1, 2);
    norm_addr = 18'd16; err_addr = 18'd48; req_addr = 18'd80; force_addr = 18'd112;
    priv = 1'b0; xj_err = 1'b0; xj_req = 1'b1;
    run_xchg("R2 normal target", 16, 1'b0);
  endtask

  task automatic t_err;
    fill(48, 1, 2);
    priv = 1'b1; xj_err = 1'b1; xj_req = 1'b1;
    run_xchg("R3 error target", 48, 1'b0);
    xj_err = 1'b0;
  endtask

  task automatic t_priv;
    fill(80, 1, 2);
    priv = 1'b1; xj_err = 1'b0; xj_req = 1'b1;
    run_xchg("R4 privileged target", 80, 1'b0);
  endtask

  task automatic t_force;
    fill(112, 1, 2);
    priv = 1'b0; xj_err = 1'b1; xj_req = 1'b1; force_req = 1'b1;
    run_xchg("R5 forced target", 112, 1'b0);
  endtask

  task automatic t_ignore;
    int bad = 0;
    fill(144, 1, 2);
    norm_addr = 18'd144; priv = 1'b0; xj_err = 1'b0; xj_req = 1'b1;
    run_xchg("R9 target kept", 144, 1'b1);
    for (int k = 0; k < WORDS; k++) if (mem[200 + k] !== pat(99, 200 + k)) bad++;
    check(bad == 0, "R9 other region untouched", bad, 0);
    @(negedge clk);
    check(!busy && !mem_en, "R10 idle after ignored request", {busy, mem_en}, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_unpriv();
    t_err();
    t_priv();
    t_force();
    t_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule